// File: doc/BRIEF.md
# Packed Colour Lookup Table with Channel Widening

This block stores a 256-colour lookup table as 128 bus-visible 32-bit words, with two 16-bit colour entries packed into each word. Software writes the words through a register window. The block keeps the raw word for read-back. It also unpacks both entries of the word into a second table that holds 8 bits per channel, ready for the pixel path.

The pixel pipeline gives an 8-bit colour index each cycle. One clock later it gets red, green and blue at 8 bits each. A 16-bit entry carries three 5-bit channels and one intensity bit, which the block ignores. Each channel is widened by placing three zero bits below it.

Top module: `clut_packed`

## Requirements
- R1: The register window covers byte addresses 0x200 up to 0x3FF. The word index is (address − 0x200) >> 2, and address bits [1:0] are ignored. A write outside the window changes no stored word and no colour entry.
- R2: A bus read inside the window returns, one clock later on `bus_rdata`, the 32-bit word last written to that index, bit for bit. A read outside the window returns zero one clock later.
- R3: A write to word n updates two colour entries in one operation. Entry 2n comes from data bits [15:0], and entry 2n+1 comes from data bits [31:16].
- R4: Within a 16-bit entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Bit 15 is ignored. Each output channel equals the 5-bit field shifted left by 3, so its three low bits are always zero.
- R5: The pixel port is registered. The colour for `pix_idx` presented in one cycle appears on `pix_red`/`pix_green`/`pix_blue` after the next rising edge. While the index stays constant and no write occurs, the output holds.
- R6: A pixel lookup in the same cycle as a write to that entry returns the old colour. A lookup one cycle later returns the new colour.
- R7: Reset clears every stored word, every colour entry and both read outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data, two packed entries |
| bus_rdata | output | 32 | Registered read data |
| pix_idx | input | 8 | Colour index from the pixel path |
| pix_red | output | 8 | Widened red channel |
| pix_green | output | 8 | Widened green channel |
| pix_blue | output | 8 | Widened blue channel |

## Verification
The bench builds the block with its default parameters: an 8-bit index, a 0x200 window base, 5-bit input channels and 8-bit output channels. At this size every one of the 128 words and all 256 entries can be written, read back and looked up in a single run. This covers every halfword split and every field position, with expected colours computed by shifting. Addresses just below and just above the window are driven as well, along with a write and a lookup of the same entry in the same cycle.

// File: rtl/clut_packed.sv
module clut_packed #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int CH_IN  = 5,
  parameter int CH_OUT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [CH_OUT-1:0] pix_red,
  output logic [CH_OUT-1:0] pix_green,
  output logic [CH_OUT-1:0] pix_blue
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int WORDS   = ENTRIES / 2;
  localparam int WAW     = IDX_W - 1;
  localparam int LIMIT   = BASE + WORDS * 4;
  localparam int PAD     = CH_OUT - CH_IN;
  localparam int RGB_W   = 3 * CH_OUT;

  logic [31:0]      raw_mem [WORDS];
  logic [RGB_W-1:0] rgb_mem [ENTRIES];

  logic [31:0]    addr_ext;
  logic [31:0]    offset;
  logic           in_win;
  logic [WAW-1:0] word;

  assign addr_ext = 32'(bus_addr);
  assign in_win   = (addr_ext >= 32'(BASE)) && (addr_ext < 32'(LIMIT));
  assign offset   = addr_ext - 32'(BASE);
  assign word     = offset[WAW+1:2];

  function automatic logic [RGB_W-1:0] widen(input logic [15:0] e);
    logic [CH_OUT-1:0] r, g, b;
    r = {e[CH_IN-1:0],         PAD'(0)};
    g = {e[2*CH_IN-1:CH_IN],   PAD'(0)};
    b = {e[3*CH_IN-1:2*CH_IN], PAD'(0)};
    return {r, g, b};
  endfunction

  logic [RGB_W-1:0] pix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) raw_mem[i] <= '0;
      for (int i = 0; i < ENTRIES; i++) rgb_mem[i] <= '0;
      bus_rdata <= '0;
      pix_q     <= '0;
    end else begin
      if (bus_wr && in_win) begin
        raw_mem[word]             <= bus_wdata;
        rgb_mem[{word, 1'b0}]     <= widen(bus_wdata[15:0]);
        rgb_mem[{word, 1'b1}]     <= widen(bus_wdata[31:16]);
      end
      if (bus_rd) bus_rdata <= in_win ? raw_mem[word] : '0;
      pix_q <= rgb_mem[pix_idx];
    end
  end

  assign pix_red   = pix_q[RGB_W-1:2*CH_OUT];
  assign pix_green = pix_q[2*CH_OUT-1:CH_OUT];
  assign pix_blue  = pix_q[CH_OUT-1:0];
endmodule

module clut_packed_chk #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int CH_IN  = 5,
  parameter int CH_OUT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [IDX_W-1:0]  pix_idx,
  input logic [CH_OUT-1:0] pix_red,
  input logic [CH_OUT-1:0] pix_green,
  input logic [CH_OUT-1:0] pix_blue
);
  localparam int PAD   = CH_OUT - CH_IN;
  localparam int LIMIT = BASE + (1 << IDX_W) * 2;

  logic outside;
  assign outside = (32'(bus_addr) < 32'(BASE)) || (32'(bus_addr) >= 32'(LIMIT));

  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_red[PAD-1:0] == '0) && (pix_green[PAD-1:0] == '0) && (pix_blue[PAD-1:0] == '0));

  a_r2_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && outside) |=> (bus_rdata == '0));

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !outside) ##1 (bus_rd && !bus_wr && (bus_addr[ADDR_W-1:2] == $past(bus_addr[ADDR_W-1:2])))
      |=> (bus_rdata == $past(bus_wdata, 2)));

  a_r5_pixel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !$past(bus_wr) && $stable(pix_idx))
      |=> ($stable(pix_red) && $stable(pix_green) && $stable(pix_blue)));

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind clut_packed clut_packed_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BASE(BASE), .CH_IN(CH_IN), .CH_OUT(CH_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pix_idx(pix_idx), .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
);

// File: tb/clut_packed_bench.sv
module clut_packed_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [7:0]  pix_red, pix_green, pix_blue;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clut_packed u_clut_packed (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
  );

  function automatic logic [31:0] pattern(input int n, input int salt);
    logic [31:0] v;
    v = 32'h9E3779B9 * 32'(n + 1 + salt);
    return v ^ (32'(n) << 20) ^ 32'(salt);
  endfunction

  function automatic logic [23:0] expand(input logic [15:0] e);
    return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic look(input logic [7:0] i, output logic [23:0] c);
    @(negedge clk);
    pix_idx = i;
    @(negedge clk);
    c = {pix_red, pix_green, pix_blue};
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [23:0] c;
    logic [31:0] w0, w127;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 rdata", bus_rdata, 32'h0);
    check("R7 pixel", {8'h0, pix_red, pix_green, pix_blue}, 32'h0);
    rst_n = 1'b1;
    rd(12'h200, d); check("R7 raw word", d, 32'h0);
    look(8'd255, c); check("R7 entry", {8'h0, c}, 32'h0);

    // R1 R3: fill all words, R2 read back with address bits [1:0] ignored
    for (int n = 0; n < 128; n++) wr(12'(12'h200 + n * 4 + (n % 4)), pattern(n, 0));
    for (int n = 0; n < 128; n++) begin
      rd(12'(12'h200 + n * 4 + ((n + 1) % 4)), d);
      check("R2 readback", d, pattern(n, 0));
    end
    // R3 R4 R5: every entry
    for (int e = 0; e < 256; e++) begin
      logic [31:0] w;
      logic [15:0] h;
      w = pattern(e / 2, 0);
      h = (e % 2 == 1) ? w[31:16] : w[15:0];
      look(8'(e), c);
      check(e % 2 == 1 ? "R3 high half" : "R3 low half", {8'h0, c}, {8'h0, expand(h)});
      check("R4 low bits", {29'h0, c[18:16] | c[10:8] | c[2:0]}, 32'h0);
    end
    // R4: intensity bit ignored
    wr(12'h204, 32'h8000_7FFF);
    look(8'd2, c); check("R4 full fields", {8'h0, c}, 32'h00F8F8F8);
    look(8'd3, c); check("R4 bit15 ignored", {8'h0, c}, 32'h0);
    wr(12'h204, 32'h0421_8421);
    look(8'd2, c); check("R4 channel order", {8'h0, c}, 32'h00080808);
    look(8'd3, c); check("R4 channel order hi", {8'h0, c}, 32'h00080808);

    // R5: hold while idle
    look(8'd2, c);
    @(negedge clk); check("R5 hold", {8'h0, pix_red, pix_green, pix_blue}, {8'h0, c});

    // R1: writes outside the window
    rd(12'h200, w0); rd(12'h3FC, w127);
    wr(12'h1FC, 32'hDEAD_BEEF);
    wr(12'h400, 32'hCAFE_F00D);
    wr(12'hFFC, 32'h1234_5678);
    rd(12'h200, d); check("R1 word0 untouched", d, w0);
    rd(12'h3FC, d); check("R1 word127 untouched", d, w127);
    look(8'd0, c); check("R1 entry0 untouched", {8'h0, c}, {8'h0, expand(w0[15:0])});
    look(8'd255, c); check("R1 entry255 untouched", {8'h0, c}, {8'h0, expand(w127[31:16])});
    // R2: outside reads are zero
    rd(12'h1FC, d); check("R2 below window", d, 32'h0);
    rd(12'h400, d); check("R2 above window", d, 32'h0);

    // R6: same-cycle write and lookup
    look(8'd10, c);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h214; bus_wdata = 32'h0000_001F; pix_idx = 8'd10;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R6 old value", {8'h0, pix_red, pix_green, pix_blue}, {8'h0, c});
    @(negedge clk);
    check("R6 new value", {8'h0, pix_red, pix_green, pix_blue}, 32'h00F80000);

    // R7: reset again clears table
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(12'h214, d); check("R7 cleared word", d, 32'h0);
    look(8'd10, c); check("R7 cleared entry", {8'h0, c}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule